// File: doc/BRIEF.md
# Contactless Request Frame Receiver

This block turns a demodulated reader data line into request frames. The line is already a clean digital level: logic 1 when idle and logic 0 during modulation. The block samples it on a clock that runs at a fixed number of cycles per elementary time unit (ETU). It looks for the long low pulse that opens a frame. It then reads 10-bit characters, each sampled at the middle of its bit cells, and recognises the long low pulse that closes the frame.

Every byte between the opening and closing patterns, including the two check bytes, goes out on a byte stream. The stream runs one byte behind the line, so the final byte can carry a last marker. In the same cycle as that marker, a single-cycle good or bad flag gives the verdict on the frame. A CRC-16 runs over all received bytes, and its residue decides the verdict. The consumer drops the bytes of a bad frame. The receiver never answers and never reports an error in any other way. After an abort it goes back to looking for a new opening pattern.

Top module: `req_frame_rx`

## Requirements
- R1: During and after reset, all outputs are 0 and the receiver waits for an opening pattern.
- R2: An opening low pulse is accepted only if it lasts between 9 and 11 ETU. A pulse of 8 ETU or 12 ETU produces no output at all.
- R3: After the opening low pulse, the high phase before the first start bit must last from 1.5 to 3.5 ETU. A high phase of 1 ETU or 5 ETU produces no output.
- R4: Each character is sampled at the middle of its ETU cells, timed from its falling edge. It is a start bit of 0, then eight data bits with the least significant bit first, then a stop bit of 1.
- R5: A character whose stop bit reads 0 while its data bits are not all 0 aborts the frame. frame_bad_o pulses, and the byte held back is never output.
- R6: The closing pattern is a character cell whose ten samples are all 0, followed by a rising edge no later than 11 ETU after its falling edge. If the low phase lasts longer, the frame aborts with frame_bad_o.
- R7: The CRC-16 starts at FFFFh and uses the reflected polynomial 8408h. The check bytes are the one's complement of the register, sent low byte first. A frame with correct check bytes gives frame_good_o. A single flipped bit gives frame_bad_o.
- R8: Every received byte is output once, in order, one character behind the line. byte_last_o marks the final byte and comes in the same cycle as frame_good_o or frame_bad_o.
- R9: frame_good_o or frame_bad_o is high in the third clock cycle after the closing rising edge reaches line_i.
- R10: An idle high time of 0 to 6 ETU between characters is accepted.
- R11: A frame with fewer than three bytes, counting the check bytes, gives frame_bad_o even when its check bytes match.
- R12: frame_good_o and frame_bad_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, ETU_CYC cycles per ETU |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Demodulated reader data, 1 = idle |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | byte_o holds a byte in this cycle |
| byte_last_o | output | 1 | The byte in this cycle is the last of the frame |
| frame_good_o | output | 1 | Frame ended with a valid check and enough bytes |
| frame_bad_o | output | 1 | Frame rejected after its opening pattern |

## Verification
The line passes through two synchronizer stages and one edge register before the decision logic, so a frame verdict is due three cycles after the closing rising edge is driven. The bench records the cycle in which it drives that edge and compares it with the cycle in which the monitor first sees the verdict. A byte appears one character after it was received, and so it can only be counted once the line has stayed idle for a few ETU. The bench therefore compares byte streams and flag counts only after a settling interval of four ETU, and never inside a frame.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SOF_LO,
    ST_SOF_HI,
    ST_CHAR,
    ST_GAP,
    ST_EOF_LO
  } rx_state_e;

  localparam logic [15:0] CRC_INIT    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY    = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

  // Reflected CRC-16, one byte, least significant bit first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic fell_o,
  output logic rose_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], line_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign fell_o = sh_q[STAGES] & ~sh_q[STAGES-1];
  assign rose_o = ~sh_q[STAGES] & sh_q[STAGES-1];
endmodule

// File: rtl/rx_crc16_acc.sv
module rx_crc16_acc import frame_rx_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic       match_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_INIT;
    else if (clear_i) crc_q <= CRC_INIT;
    else if (en_i)    crc_q <= crc16_byte(crc_q, data_i);
  end

  assign match_o = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] data_i,
  input  logic       end_i,
  input  logic       abort_i,
  input  logic       pass_i,
  output logic [7:0] byte_o,
  output logic       valid_o,
  output logic       last_o,
  output logic       good_o,
  output logic       bad_o
);
  logic [7:0] held_q;
  logic       have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= '0;
      have_q  <= 1'b0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      good_o  <= 1'b0;
      bad_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      good_o  <= 1'b0;
      bad_o   <= 1'b0;
      if (push_i) begin
        if (have_q) begin
          byte_o  <= held_q;
          valid_o <= 1'b1;
        end
        held_q <= data_i;
        have_q <= 1'b1;
      end
      if (end_i) begin
        if (have_q) begin
          byte_o  <= held_q;
          valid_o <= 1'b1;
          last_o  <= 1'b1;
        end
        have_q <= 1'b0;
        good_o <= pass_i;
        bad_o  <= ~pass_i;
      end
      if (abort_i) begin
        have_q <= 1'b0;
        bad_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/req_frame_rx.sv
module req_frame_rx import frame_rx_pkg::*; #(
  parameter int ETU_CYC        = 16,
  parameter int LOW_ETU        = 10,
  parameter int LOW_TOL_ETU    = 1,
  parameter int SOF_HI_MIN_ETU = 2,
  parameter int SOF_HI_MAX_ETU = 3,
  parameter int MIN_BYTES      = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       byte_last_o,
  output logic       frame_good_o,
  output logic       frame_bad_o
);
  localparam int HALF_I    = ETU_CYC / 2;
  localparam int LOW_MIN_I = (LOW_ETU - LOW_TOL_ETU) * ETU_CYC;
  localparam int LOW_MAX_I = (LOW_ETU + LOW_TOL_ETU) * ETU_CYC;
  localparam int HI_MIN_I  = SOF_HI_MIN_ETU * ETU_CYC - HALF_I;
  localparam int HI_MAX_I  = SOF_HI_MAX_ETU * ETU_CYC + HALF_I;
  localparam int SAT_I     = ((LOW_MAX_I > HI_MAX_I) ? LOW_MAX_I : HI_MAX_I) + ETU_CYC;
  localparam int DUR_W     = $clog2(SAT_I + 1);
  localparam int CHAR_BITS = 10;
  localparam int BIT_W     = $clog2(CHAR_BITS);
  localparam int NB_W      = $clog2(MIN_BYTES + 1);

  localparam logic [DUR_W-1:0] LOW_MIN  = LOW_MIN_I[DUR_W-1:0];
  localparam logic [DUR_W-1:0] LOW_MAX  = LOW_MAX_I[DUR_W-1:0];
  localparam logic [DUR_W-1:0] HI_MIN   = HI_MIN_I[DUR_W-1:0];
  localparam logic [DUR_W-1:0] HI_MAX   = HI_MAX_I[DUR_W-1:0];
  localparam logic [DUR_W-1:0] DUR_SAT  = SAT_I[DUR_W-1:0];
  localparam logic [DUR_W-1:0] HALF     = HALF_I[DUR_W-1:0];
  localparam logic [DUR_W-1:0] ETU      = ETU_CYC[DUR_W-1:0];
  localparam logic [BIT_W-1:0] STOP_IDX = BIT_W'(CHAR_BITS - 1);
  localparam logic [NB_W-1:0]  NB_MIN   = MIN_BYTES[NB_W-1:0];

  // line events
  logic lvl_w, fell_w, rose_w;

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .lvl_o  (lvl_w),
    .fell_o (fell_w),
    .rose_o (rose_w)
  );

  rx_state_e        state_q, state_d;
  logic [DUR_W-1:0] dur_q, samp_at_q;
  logic [BIT_W-1:0] bit_idx_q;
  logic [7:0]       sr_q;
  logic [NB_W-1:0]  nbytes_q;

  // named internal events
  logic restart_w, sample_w, frame_start_w, byte_done_w, frame_end_w, frame_abort_w;
  logic crc_match_w, pass_w;

  assign sample_w = (state_q == ST_CHAR) && (dur_q == samp_at_q);
  assign pass_w   = crc_match_w && (nbytes_q >= NB_MIN);

  always_comb begin
    state_d       = state_q;
    restart_w     = 1'b0;
    frame_start_w = 1'b0;
    byte_done_w   = 1'b0;
    frame_end_w   = 1'b0;
    frame_abort_w = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (fell_w) begin
          state_d   = ST_SOF_LO;
          restart_w = 1'b1;
        end
      end
      ST_SOF_LO: begin
        if (rose_w) begin
          restart_w = 1'b1;
          state_d   = (dur_q >= LOW_MIN) ? ST_SOF_HI : ST_HUNT;
        end else if (dur_q > LOW_MAX) begin
          state_d = ST_HUNT;
        end
      end
      ST_SOF_HI: begin
        if (fell_w) begin
          restart_w = 1'b1;
          if (dur_q >= HI_MIN) begin
            state_d       = ST_CHAR;
            frame_start_w = 1'b1;
          end else begin
            state_d = ST_HUNT;
          end
        end else if (dur_q > HI_MAX) begin
          state_d = ST_HUNT;
        end
      end
      ST_CHAR: begin
        if (sample_w) begin
          if (bit_idx_q == '0 && lvl_w) begin
            frame_abort_w = 1'b1;
          end else if (bit_idx_q == STOP_IDX) begin
            if (lvl_w) begin
              byte_done_w = 1'b1;
              state_d     = ST_GAP;
            end else if (sr_q == 8'h00) begin
              state_d = ST_EOF_LO;
            end else begin
              frame_abort_w = 1'b1;
            end
          end
        end
      end
      ST_GAP: begin
        if (fell_w) begin
          state_d   = ST_CHAR;
          restart_w = 1'b1;
        end
      end
      ST_EOF_LO: begin
        if (rose_w) begin
          frame_end_w = 1'b1;
          state_d     = ST_HUNT;
        end else if (dur_q > LOW_MAX) begin
          frame_abort_w = 1'b1;
        end
      end
      default: state_d = ST_HUNT;
    endcase
    if (frame_abort_w) state_d = ST_HUNT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      dur_q     <= '0;
      samp_at_q <= '0;
      bit_idx_q <= '0;
      sr_q      <= '0;
      nbytes_q  <= '0;
    end else begin
      state_q <= state_d;
      if (restart_w)             dur_q <= '0;
      else if (dur_q != DUR_SAT) dur_q <= dur_q + 1'b1;
      if (restart_w) begin
        samp_at_q <= HALF;
        bit_idx_q <= '0;
      end else if (sample_w) begin
        samp_at_q <= samp_at_q + ETU;
        bit_idx_q <= bit_idx_q + 1'b1;
        if (bit_idx_q != '0 && bit_idx_q != STOP_IDX) sr_q <= {lvl_w, sr_q[7:1]};
      end
      if (frame_start_w)                     nbytes_q <= '0;
      else if (byte_done_w && nbytes_q != NB_MIN) nbytes_q <= nbytes_q + 1'b1;
    end
  end

  rx_crc16_acc crc_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (frame_start_w),
    .en_i    (byte_done_w),
    .data_i  (sr_q),
    .match_o (crc_match_w)
  );

  rx_out_stage out_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (byte_done_w),
    .data_i  (sr_q),
    .end_i   (frame_end_w),
    .abort_i (frame_abort_w),
    .pass_i  (pass_w),
    .byte_o  (byte_o),
    .valid_o (byte_valid_o),
    .last_o  (byte_last_o),
    .good_o  (frame_good_o),
    .bad_o   (frame_bad_o)
  );
endmodule

// File: rtl/req_frame_rx_chk.sv
module req_frame_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_valid_o,
  input logic byte_last_o,
  input logic frame_good_o,
  input logic frame_bad_o,
  input logic frame_end_w,
  input logic frame_abort_w
);
  // R12
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_good_o && frame_bad_o));

  // R12
  good_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_good_o |=> !frame_good_o);

  // R12
  bad_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_bad_o |=> !frame_bad_o);

  // R8
  last_with_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_last_o |-> (byte_valid_o && (frame_good_o || frame_bad_o)));

  // R11
  good_has_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_good_o |-> byte_last_o);

  // R8
  end_gives_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_w |=> (frame_good_o || frame_bad_o));

  // R5
  abort_drops_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_abort_w |=> (frame_bad_o && !byte_valid_o));

  // R4
  byte_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);
endmodule

bind req_frame_rx req_frame_rx_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .byte_valid_o  (byte_valid_o),
  .byte_last_o   (byte_last_o),
  .frame_good_o  (frame_good_o),
  .frame_bad_o   (frame_bad_o),
  .frame_end_w   (frame_end_w),
  .frame_abort_w (frame_abort_w)
);

// File: tb/req_frame_rx_tb_top.sv
module req_frame_rx_tb_top;
  localparam int E = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic [7:0] byte_o;
  logic byte_valid_o, byte_last_o, frame_good_o, frame_bad_o;

  always #5 clk = ~clk;

  req_frame_rx #(.ETU_CYC(E)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .line_i       (line),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .byte_last_o  (byte_last_o),
    .frame_good_o (frame_good_o),
    .frame_bad_o  (frame_bad_o)
  );

  // n, payload bytes (first at top), gap ETU, opening high ETU
  localparam logic [47:0] VECS [6] = '{
    {8'd2, 32'h0600_0000, 4'd0, 4'd2},
    {8'd2, 32'h0604_0000, 4'd3, 4'd3},
    {8'd2, 32'h0E5A_0000, 4'd6, 4'd2},
    {8'd2, 32'h082A_0000, 4'd1, 4'd2},
    {8'd4, 32'h0907_BEEF, 4'd2, 4'd3},
    {8'd1, 32'h0F00_0000, 4'd0, 4'd2}
  };

  int checks = 0, failures = 0;
  int cyc = 0;
  logic [7:0] tx_buf [0:15];
  int tx_n;
  logic [7:0] rx_buf [0:31];
  int rx_n, last_idx, good_cnt, bad_cnt, res_cyc, rise_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid_o) begin
        if (rx_n < 32) rx_buf[rx_n] = byte_o;
        if (byte_last_o) last_idx = rx_n;
        rx_n++;
      end
      if (frame_good_o) begin good_cnt++; res_cyc = cyc; end
      if (frame_bad_o)  begin bad_cnt++;  res_cyc = cyc; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_n = 0; last_idx = -1; good_cnt = 0; bad_cnt = 0; res_cyc = -1;
  endtask

  task automatic hold(input logic lv, input int n);
    line = lv;
    repeat (n) @(negedge clk);
  endtask

  // bit-serial CRC, complemented, appended low byte first
  task automatic add_crc();
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int i = 0; i < tx_n; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ tx_buf[i][b];
        c = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'h8408;
      end
    c = ~c;
    tx_buf[tx_n] = c[7:0];
    tx_buf[tx_n+1] = c[15:8];
    tx_n += 2;
  endtask

  task automatic send_char(input logic [7:0] d, input logic stop);
    hold(1'b0, E);
    for (int b = 0; b < 8; b++) hold(d[b], E);
    hold(stop, E);
  endtask

  task automatic send_frame(input int sof_lo, input int sof_hi, input int gap, input int eof_lo);
    hold(1'b1, 3 * E);
    hold(1'b0, sof_lo);
    hold(1'b1, sof_hi);
    for (int i = 0; i < tx_n; i++) begin
      send_char(tx_buf[i], 1'b1);
      if (gap > 0) hold(1'b1, gap);
    end
    hold(1'b0, eof_lo);
    line = 1'b1;
    rise_cyc = cyc;
    hold(1'b1, 4 * E);
  endtask

  task automatic expect_good(input string req);
    int mism;
    mism = 0;
    for (int i = 0; i < tx_n; i++) if (i >= rx_n || rx_buf[i] !== tx_buf[i]) mism++;
    chk(good_cnt == 1 && bad_cnt == 0, req, good_cnt, 1);
    chk(rx_n == tx_n, "R8 byte count", rx_n, tx_n);
    chk(mism == 0, "R4 byte values", mism, 0);
    chk(last_idx == tx_n - 1, "R8 last position", last_idx, tx_n - 1);
    chk(res_cyc - rise_cyc == 3, "R9 verdict latency", res_cyc - rise_cyc, 3);
  endtask

  task automatic expect_nothing(input string req);
    chk(rx_n == 0 && good_cnt == 0 && bad_cnt == 0, req, rx_n + good_cnt + bad_cnt, 0);
  endtask

  task automatic load_std();
    tx_buf[0] = 8'h08; tx_buf[1] = 8'h11; tx_n = 2;
    add_crc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    // R1 outputs during reset
    chk({byte_valid_o, byte_last_o, frame_good_o, frame_bad_o} == 4'b0, "R1 reset outputs",
        {byte_valid_o, byte_last_o, frame_good_o, frame_bad_o}, 0);
    rst_n = 1'b1;
    hold(1'b1, 4 * E);
    expect_nothing("R1 idle after reset");

    // table walk: R7 R10 R4 R8 R9 R3
    foreach (VECS[v]) begin
      tx_n = int'(VECS[v][47:40]);
      for (int i = 0; i < tx_n; i++) tx_buf[i] = VECS[v][39 - 8*i -: 8];
      add_crc();
      clear_mon();
      send_frame(10 * E, int'(VECS[v][3:0]) * E, int'(VECS[v][7:4]) * E, 10 * E);
      expect_good("R7 R10 vector frame good");
    end

    // R2 opening low at tolerance edges, accepted
    load_std(); clear_mon();
    send_frame(9 * E + E / 2, 2 * E, 0, 10 * E);
    chk(good_cnt == 1, "R2 opening 9.5 ETU accepted", good_cnt, 1);
    load_std(); clear_mon();
    send_frame(10 * E + E / 2, 2 * E, 0, 10 * E);
    chk(good_cnt == 1, "R2 opening 10.5 ETU accepted", good_cnt, 1);

    // R2 rejected opening lengths
    load_std(); clear_mon();
    send_frame(8 * E, 2 * E, 0, 10 * E);
    hold(1'b1, 5 * E);
    expect_nothing("R2 opening 8 ETU ignored");
    load_std(); clear_mon();
    send_frame(12 * E, 2 * E, 0, 10 * E);
    hold(1'b1, 5 * E);
    expect_nothing("R2 opening 12 ETU ignored");

    // R3 high phase limits
    load_std(); clear_mon();
    send_frame(10 * E, 1 * E, 0, 10 * E);
    hold(1'b1, 5 * E);
    expect_nothing("R3 high 1 ETU ignored");
    load_std(); clear_mon();
    send_frame(10 * E, 5 * E, 0, 10 * E);
    hold(1'b1, 5 * E);
    expect_nothing("R3 high 5 ETU ignored");

    // R7 corrupted check byte
    load_std(); tx_buf[2] = tx_buf[2] ^ 8'h01; clear_mon();
    send_frame(10 * E, 2 * E, 0, 10 * E);
    chk(bad_cnt == 1 && good_cnt == 0, "R7 corrupt check gives bad", bad_cnt, 1);
    chk(last_idx == 3, "R8 last on bad frame", last_idx, 3);

    // R11 empty payload: 00 00 matches residue but is too short
    tx_n = 0; add_crc(); clear_mon();
    send_frame(10 * E, 2 * E, 0, 10 * E);
    chk(bad_cnt == 1 && good_cnt == 0, "R11 two-byte frame bad", bad_cnt, 1);
    chk(rx_n == 2, "R11 bytes still streamed", rx_n, 2);

    // R6 closing low too long
    load_std(); clear_mon();
    send_frame(10 * E, 2 * E, 0, 12 * E);
    chk(bad_cnt == 1 && good_cnt == 0, "R6 long closing gives bad", bad_cnt, 1);
    chk(last_idx == -1, "R6 no last byte", last_idx, -1);

    // R5 stop bit 0 with nonzero data
    clear_mon();
    hold(1'b1, 3 * E);
    hold(1'b0, 10 * E);
    hold(1'b1, 2 * E);
    send_char(8'h06, 1'b1);
    send_char(8'h55, 1'b0);
    hold(1'b1, 20 * E);
    chk(bad_cnt == 1 && good_cnt == 0, "R5 stop error gives bad", bad_cnt, 1);
    chk(rx_n == 0, "R5 held byte dropped", rx_n, 0);

    // R12 recovery after abort: next frame good with one verdict
    load_std(); clear_mon();
    send_frame(10 * E, 2 * E, 0, 10 * E);
    chk(good_cnt == 1 && bad_cnt == 0, "R12 single verdict after abort", good_cnt + bad_cnt, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule